// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port with Address-Bus Override

This block is a small general-purpose I/O port for a microcontroller. Software reaches it through a simple register bus. It controls four pins through five registers: direction, output data, pull-up enable, open-drain enable, and a read-only view of the synchronized pin levels. The block does not contain pads or resistors. It only produces the per-pin output-enable, output-value and pull-up-enable signals that the pad ring uses, and it takes back the raw pin levels.

The chip can run in several operating modes. In the expanded modes (mode codes 4, 5 and 6), a pin-function field can hand any pin over to the address bus, and this takes priority over the direction bit. Two standby inputs are also handled:
- Hardware standby clears the direction state, as reset does.
- Software standby keeps the direction state. A separate hold control then decides whether address pins keep driving their last level or float.

Top module: `gpx_port`

## Requirements
- R1: While `rst` is high, the direction, data, pull-up and open-drain registers clear to 0. On the edge after reset, `pad_oe`, `pad_do`, `pad_pu` and `bus_rdata` are all 0.
- R2: Register offsets are: direction 0x0000, data 0x0001, pin state 0x0002, pull-up 0x0003, open-drain 0x0004.
  - A write (`bus_we`) updates the register on the clock edge where the strobe is sampled, using `bus_wdata[3:0]`.
  - A read (`bus_re`) returns the register in `bus_rdata[3:0]` on the next edge.
  - `bus_rdata[7:4]` always reads 0, and so does any unmapped offset.
- R3: The direction register is write-only. A read of its offset returns 0x00 whatever it holds.
- R4: When a pin is not an address pin, direction bit 1 makes it an output port with `pad_oe`=1 and `pad_do` equal to its data bit. Direction bit 0 gives `pad_oe`=0 and `pad_do`=0.
- R5: An output port pin whose open-drain bit is 1 drives `pad_do`=0, with `pad_oe`=1 for data 0 and `pad_oe`=0 for data 1.
- R6: `pad_pu` for a pin is 1 only when the pin is an input port (direction 0, not an address pin) and its pull-up bit is 1. It is never 1 together with `pad_oe`.
- R7: The pin-state register returns `pad_di` through a two-flop synchronizer.
  - A read sampled on the first edge after a pin change still returns the old level.
  - A read sampled on the third edge returns the new level.
- R8: When `mode` is 4, 5 or 6 and `addr_en[i]` is 1, pin i becomes an address pin: `pad_oe[i]`=1 and `pad_do[i]`=`addr_bits[i]`, whatever its direction bit.
  - In any other mode `addr_en` has no effect.
- R9: While `hw_stby` is high, the direction register clears to 0 and direction writes are ignored. The data register keeps its value. `sw_stby` leaves the direction register unchanged.
- R10: While `sw_stby` is high, address pins follow `hold_en`:
  - With `hold_en`=1 they keep `pad_oe`=1 and their last `pad_do`, and ignore changes on `addr_bits`.
  - With `hold_en`=0 they float (`pad_oe`=0).
- R11: The pad outputs are registered. They change one edge after the register state or the mode, field or standby inputs that decide them. After a register write, that is the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby; clears direction |
| sw_stby | input | 1 | Software standby |
| hold_en | input | 1 | In software standby: 1 = address pins hold, 0 = float |
| mode | input | 3 | Operating mode code; 4 to 6 are expanded modes |
| addr_en | input | 4 | Per-pin address-output enable field |
| addr_bits | input | 4 | Address-bus bits routed to the pins |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_di | input | 4 | Raw pin input levels |
| pad_oe | output | 4 | Per-pin output enable |
| pad_do | output | 4 | Per-pin output value |
| pad_pu | output | 4 | Per-pin pull-up enable |

## Verification
Each result has its own latency after its stimulus:
- Read data is due one edge after the read strobe.
- Pad outputs are due one edge after a change on the mode, field or standby inputs, and two edges after a register write.
- A pin change reaches a read only when the read is sampled on the third edge.

The bench drives every input on the falling edge and counts rising edges before it samples on a later falling edge. It also samples one edge early in the latency and synchronizer cases, to show that the old value is still present then.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  // Register selector decoded from the bus offset
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_DAT  = 3'd2,
    SEL_PIN  = 3'd3,
    SEL_PU   = 3'd4,
    SEL_OD   = 3'd5
  } reg_sel_e;

  // Expanded-mode code window in which address override applies
  localparam int unsigned EXP_MODE_LO = 4;
  localparam int unsigned EXP_MODE_HI = 6;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  // Two-flop synchronizer, one chain per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_in[i];
        s2 <= s1;
      end
    end
    assign d_out[i] = s2;
  end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int unsigned NPIN  = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter logic [AW-1:0] A_DIR = 16'h0000,
  parameter logic [AW-1:0] A_DAT = 16'h0001,
  parameter logic [AW-1:0] A_PIN = 16'h0002,
  parameter logic [AW-1:0] A_PU  = 16'h0003,
  parameter logic [AW-1:0] A_OD  = 16'h0004
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hw_stby,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [NPIN-1:0] pin_sync,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] dat_q,
  output logic [NPIN-1:0] pu_q,
  output logic [NPIN-1:0] od_q,
  output logic [DW-1:0]   bus_rdata
);
  reg_sel_e        sel;
  logic [NPIN-1:0] wval;
  logic [DW-1:0]   rd_next;
  logic            unused_wdata_hi;

  assign wval            = bus_wdata[NPIN-1:0];
  assign unused_wdata_hi = ^bus_wdata[DW-1:NPIN];

  always_comb begin
    if      (bus_addr == A_DIR) sel = SEL_DIR;
    else if (bus_addr == A_DAT) sel = SEL_DAT;
    else if (bus_addr == A_PIN) sel = SEL_PIN;
    else if (bus_addr == A_PU)  sel = SEL_PU;
    else if (bus_addr == A_OD)  sel = SEL_OD;
    else                        sel = SEL_NONE;
  end

  // Direction: cleared by reset and by hardware standby
  always_ff @(posedge clk) begin
    if (rst || hw_stby)                dir_q <= '0;
    else if (bus_we && sel == SEL_DIR) dir_q <= wval;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      pu_q  <= '0;
      od_q  <= '0;
    end else if (bus_we) begin
      if (sel == SEL_DAT) dat_q <= wval;
      if (sel == SEL_PU)  pu_q  <= wval;
      if (sel == SEL_OD)  od_q  <= wval;
    end
  end

  // Read mux; direction is write-only and reads as zero
  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DAT: rd_next[NPIN-1:0] = dat_q;
      SEL_PIN: rd_next[NPIN-1:0] = pin_sync;
      SEL_PU:  rd_next[NPIN-1:0] = pu_q;
      SEL_OD:  rd_next[NPIN-1:0] = od_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpx_padctl.sv
module gpx_padctl
  import gpx_pkg::*;
#(
  parameter int unsigned NPIN = 4,
  parameter int unsigned MW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MW-1:0]   mode,
  input  logic [NPIN-1:0] addr_en,
  input  logic [NPIN-1:0] addr_bits,
  input  logic            sw_stby,
  input  logic            hold_en,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] dat_q,
  input  logic [NPIN-1:0] pu_q,
  input  logic [NPIN-1:0] od_q,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_pu
);
  localparam logic [MW-1:0] M_LO = MW'(EXP_MODE_LO);
  localparam logic [MW-1:0] M_HI = MW'(EXP_MODE_HI);

  logic expanded;
  assign expanded = (mode >= M_LO) && (mode <= M_HI);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic ovr;
    assign ovr = expanded && addr_en[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i] <= 1'b0;
        pad_do[i] <= 1'b0;
        pad_pu[i] <= 1'b0;
      end else if (ovr) begin
        pad_pu[i] <= 1'b0;
        if (sw_stby) begin
          pad_oe[i] <= hold_en;          // hold keeps last pad_do
        end else begin
          pad_oe[i] <= 1'b1;
          pad_do[i] <= addr_bits[i];
        end
      end else if (dir_q[i]) begin
        pad_pu[i] <= 1'b0;
        if (od_q[i]) begin
          pad_oe[i] <= ~dat_q[i];
          pad_do[i] <= 1'b0;
        end else begin
          pad_oe[i] <= 1'b1;
          pad_do[i] <= dat_q[i];
        end
      end else begin
        pad_oe[i] <= 1'b0;
        pad_do[i] <= 1'b0;
        pad_pu[i] <= pu_q[i];
      end
    end
  end
endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
  parameter int unsigned NPIN  = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned MW    = 3,
  parameter logic [AW-1:0] A_DIR = 16'h0000,
  parameter logic [AW-1:0] A_DAT = 16'h0001,
  parameter logic [AW-1:0] A_PIN = 16'h0002,
  parameter logic [AW-1:0] A_PU  = 16'h0003,
  parameter logic [AW-1:0] A_OD  = 16'h0004
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hw_stby,
  input  logic            sw_stby,
  input  logic            hold_en,
  input  logic [MW-1:0]   mode,
  input  logic [NPIN-1:0] addr_en,
  input  logic [NPIN-1:0] addr_bits,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pad_di,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_pu
);
  logic [NPIN-1:0] pin_sync, dir_q, dat_q, pu_q, od_q;

  gpx_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d_in(pad_di), .d_out(pin_sync)
  );

  gpx_regs #(
    .NPIN(NPIN), .AW(AW), .DW(DW),
    .A_DIR(A_DIR), .A_DAT(A_DAT), .A_PIN(A_PIN), .A_PU(A_PU), .A_OD(A_OD)
  ) u_regs (
    .clk(clk), .rst(rst), .hw_stby(hw_stby),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .pin_sync(pin_sync),
    .dir_q(dir_q), .dat_q(dat_q), .pu_q(pu_q), .od_q(od_q),
    .bus_rdata(bus_rdata)
  );

  gpx_padctl #(.NPIN(NPIN), .MW(MW)) u_padctl (
    .clk(clk), .rst(rst), .mode(mode), .addr_en(addr_en), .addr_bits(addr_bits),
    .sw_stby(sw_stby), .hold_en(hold_en),
    .dir_q(dir_q), .dat_q(dat_q), .pu_q(pu_q), .od_q(od_q),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
  );
endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk #(
  parameter int unsigned NPIN  = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned MW    = 3,
  parameter logic [AW-1:0] A_DIR = 16'h0000
) (
  input logic            clk,
  input logic            rst,
  input logic            sw_stby,
  input logic            hold_en,
  input logic [MW-1:0]   mode,
  input logic [NPIN-1:0] addr_en,
  input logic [NPIN-1:0] addr_bits,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_re,
  input logic [DW-1:0]   bus_rdata,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_do,
  input logic [NPIN-1:0] pad_pu
);
  logic [NPIN-1:0] ovr_mask;
  assign ovr_mask = ((mode >= MW'(4)) && (mode <= MW'(6))) ? addr_en : '0;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_pu == '0 && bus_rdata == '0)); // R1

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DW-1:NPIN] == '0); // R2

  AST_DIR_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == A_DIR) |=> bus_rdata == '0); // R3

  AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_oe) == '0); // R6

  AST_ADDR_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    !sw_stby |=> (((pad_oe & $past(ovr_mask)) == $past(ovr_mask)) &&
                  (((pad_do ^ $past(addr_bits)) & $past(ovr_mask)) == '0))); // R8

  AST_SWSTBY_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (sw_stby && !hold_en) |=> (pad_oe & $past(ovr_mask)) == '0); // R10

  AST_SWSTBY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sw_stby && hold_en && $past(ovr_mask) == ovr_mask) |=>
      ((pad_do ^ $past(pad_do)) & $past(ovr_mask)) == '0); // R10
endmodule

bind gpx_port gpx_port_chk #(
  .NPIN(NPIN), .AW(AW), .DW(DW), .MW(MW), .A_DIR(A_DIR)
) u_chk (
  .clk(clk), .rst(rst), .sw_stby(sw_stby), .hold_en(hold_en), .mode(mode),
  .addr_en(addr_en), .addr_bits(addr_bits), .bus_addr(bus_addr),
  .bus_re(bus_re), .bus_rdata(bus_rdata),
  .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
);

// File: tb/gpx_port_bench.sv
`timescale 1ns/1ps
module gpx_port_bench;
  localparam logic [15:0] O_DIR = 16'h0000;
  localparam logic [15:0] O_DAT = 16'h0001;
  localparam logic [15:0] O_PIN = 16'h0002;
  localparam logic [15:0] O_PU  = 16'h0003;
  localparam logic [15:0] O_OD  = 16'h0004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_stby = 1'b0, sw_stby = 1'b0, hold_en = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [3:0]  addr_en = 4'h0, addr_bits = 4'h0;
  logic [15:0] bus_addr = 16'h0;
  logic [7:0]  bus_wdata = 8'h0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic [3:0]  pad_di = 4'h0;
  logic [3:0]  pad_oe, pad_do, pad_pu;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpx_port u_gpx_port (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby), .hold_en(hold_en),
    .mode(mode), .addr_en(addr_en), .addr_bits(addr_bits),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .pad_di(pad_di),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Write: strobe sampled on next rising edge; returns at following falling edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 oe", {4'h0, pad_oe}, 8'h00);
    chk("R1 do", {4'h0, pad_do}, 8'h00);
    chk("R1 pu", {4'h0, pad_pu}, 8'h00);
    rd(O_DAT, v); chk("R1 dat", v, 8'h00);
    rd(O_PU, v);  chk("R1 pu reg", v, 8'h00);
    rd(O_OD, v);  chk("R1 od reg", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(O_DAT, 8'hF9); rd(O_DAT, v); chk("R2 dat readback", v, 8'h09);
    wr(O_PU, 8'hA6);  rd(O_PU, v);  chk("R2 pu readback", v, 8'h06);
    wr(O_OD, 8'h5C);  rd(O_OD, v);  chk("R2 od readback", v, 8'h0C);
    rd(16'h0040, v);  chk("R2 unmapped", v, 8'h00);
    wr(O_PU, 8'h00); wr(O_OD, 8'h00); wr(O_DAT, 8'h00);
  endtask

  task automatic t_dir_wo();
    logic [7:0] v;
    wr(O_DIR, 8'h0F); tick(1);
    rd(O_DIR, v); chk("R3 dir reads zero", v, 8'h00);
    chk("R3 dir stored (oe)", {4'h0, pad_oe}, 8'h0F);
    wr(O_DIR, 8'h00); tick(1);
  endtask

  task automatic t_drive();
    wr(O_DAT, 8'h0A); wr(O_DIR, 8'h06); tick(1);
    chk("R4 oe", {4'h0, pad_oe}, 8'h06);
    chk("R4 do", {4'h0, pad_do}, 8'h02);
    wr(O_DIR, 8'h00); tick(1);
  endtask

  task automatic t_latency();
    wr(O_DAT, 8'h00); wr(O_DIR, 8'h0F); tick(1);
    wr(O_DAT, 8'h0F);
    chk("R11 one edge after write", {4'h0, pad_do}, 8'h00);
    tick(1);
    chk("R11 two edges after write", {4'h0, pad_do}, 8'h0F);
    wr(O_DIR, 8'h00); wr(O_DAT, 8'h00); tick(1);
  endtask

  task automatic t_open_drain();
    wr(O_DAT, 8'h05); wr(O_OD, 8'h03); wr(O_DIR, 8'h0F); tick(1);
    chk("R5 oe", {4'h0, pad_oe}, 8'h0E);
    chk("R5 do", {4'h0, pad_do}, 8'h04);
    wr(O_DIR, 8'h00); wr(O_OD, 8'h00); wr(O_DAT, 8'h00); tick(1);
  endtask

  task automatic t_pullup();
    wr(O_DIR, 8'h03); wr(O_PU, 8'h0F); tick(1);
    chk("R6 pu inputs only", {4'h0, pad_pu}, 8'h0C);
    mode = 3'd4; addr_en = 4'h4; tick(1);
    chk("R6 pu off on addr pin", {4'h0, pad_pu}, 8'h08);
    mode = 3'd0; addr_en = 4'h0;
    wr(O_DIR, 8'h00); wr(O_PU, 8'h00); tick(1);
  endtask

  task automatic t_pin_read();
    logic [7:0] v;
    pad_di = 4'hA;
    rd(O_PIN, v); chk("R7 first edge old", v, 8'h00);
    tick(1);
    rd(O_PIN, v); chk("R7 third edge new", v, 8'h0A);
    pad_di = 4'h0; tick(3);
  endtask

  task automatic t_override();
    wr(O_DIR, 8'h00); addr_bits = 4'hF; addr_en = 4'h5; mode = 3'd4; tick(1);
    chk("R8 mode4 oe", {4'h0, pad_oe}, 8'h05);
    chk("R8 mode4 do", {4'h0, pad_do}, 8'h05);
    mode = 3'd2; tick(1);
    chk("R8 mode2 ignored", {4'h0, pad_oe}, 8'h00);
    mode = 3'd7; tick(1);
    chk("R8 mode7 ignored", {4'h0, pad_oe}, 8'h00);
    wr(O_DAT, 8'h00); wr(O_DIR, 8'h0F);
    mode = 3'd6; addr_bits = 4'h1; tick(1);
    chk("R8 beats dir oe", {4'h0, pad_oe}, 8'h0F);
    chk("R8 beats dir do", {4'h0, pad_do}, 8'h01);
    mode = 3'd0; addr_en = 4'h0; addr_bits = 4'h0;
    wr(O_DIR, 8'h00); tick(1);
  endtask

  task automatic t_hw_stby();
    logic [7:0] v;
    wr(O_DAT, 8'h03); wr(O_DIR, 8'h0F); tick(1);
    hw_stby = 1'b1; tick(1);
    wr(O_DIR, 8'h0F);
    hw_stby = 1'b0; tick(1);
    chk("R9 hw standby clears dir", {4'h0, pad_oe}, 8'h00);
    rd(O_DAT, v); chk("R9 data kept", v, 8'h03);
    wr(O_DIR, 8'h0F); tick(1);
    sw_stby = 1'b1; tick(2);
    chk("R9 sw standby keeps dir", {4'h0, pad_oe}, 8'h0F);
    sw_stby = 1'b0;
    wr(O_DIR, 8'h00); wr(O_DAT, 8'h00); tick(1);
  endtask

  task automatic t_sw_stby();
    mode = 3'd5; addr_en = 4'hF; addr_bits = 4'hA; tick(1);
    hold_en = 1'b1; sw_stby = 1'b1; tick(1);
    addr_bits = 4'h5; tick(1);
    chk("R10 hold oe", {4'h0, pad_oe}, 8'h0F);
    chk("R10 hold do", {4'h0, pad_do}, 8'h0A);
    hold_en = 1'b0; tick(1);
    chk("R10 float", {4'h0, pad_oe}, 8'h00);
    sw_stby = 1'b0; tick(1);
    chk("R10 exit oe", {4'h0, pad_oe}, 8'h0F);
    chk("R10 exit do", {4'h0, pad_do}, 8'h05);
    mode = 3'd0; addr_en = 4'h0; tick(1);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_regs();
    t_dir_wo();
    t_drive();
    t_latency();
    t_open_drain();
    t_pullup();
    t_pin_read();
    t_override();
    t_hw_stby();
    t_sw_stby();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule